// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words from a slow three-wire serial port (serial clock, serial data, load strobe) and files each word into one of four parallel holding latches. Each latch holds the divider settings for one of two synthesizer channels. The serial lines are asynchronous to the system clock, so each one is resynchronised, and its rising edges are detected inside the system clock domain.

Bits enter a 22-bit shift register, most significant bit first, on each rising edge of the serial clock. A rising edge of the load strobe copies the word into the latch named by the word's two lowest bits. A one-cycle update strobe and a 2-bit index report which latch was written. A sticky flag records whether the word just loaded was framed with a bit count other than 22.

Top module: `cfg3w_loader`

## Requirements
- R1: Each serial line passes through a two-flop synchroniser. A load-strobe rise applied just before system edge e writes the latch and raises `upd_o` at edge e+2. The output is seen after that edge and not before it.
- R2: The shift register is 22 bits wide and fills most significant bit first. After 22 serial clock rises, the first bit sent is at bit 21 and the last bit sent is at bit 0.
- R3: Only a rising edge of the serial clock shifts a bit in. Data changes while the serial clock is steady, and falling serial clock edges, leave the register unchanged.
- R4: A transfer happens only on a rising edge of the load strobe. Holding the strobe high causes no further transfers, and bits shifted while it is high are kept for the next rise.
- R5: Bits [1:0] of the word select the latch: 00 goes to `ch2_ref_o`, 01 to `ch2_div_o`, 10 to `ch1_ref_o` and 11 to `ch1_div_o`. The other three latches keep their contents.
- R6: A latch keeps the whole 22-bit word, control bits included. In a reference latch, the 14-bit divider value appears at bits [15:2].
- R7: `upd_o` is high for exactly one cycle per transfer. `upd_idx_o` shows the 2-bit selector of that transfer and holds it until the next transfer.
- R8: `short_o` is set at a transfer when the number of serial clock rises since the previous transfer (or since reset) was not exactly 22, and cleared at a transfer when it was 22. The register contents are still transferred in either case, and the flag holds between transfers.
- R9: After reset, all four latches, `upd_o`, `upd_idx_o` and `short_o` are zero.
- R10: If a serial clock rise and a load-strobe rise are detected in the same cycle, the bit is shifted in first. The word transferred includes that bit, and the bit counts toward the 22 for R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous) |
| ch2_ref_o | output | 22 | Latch for selector 00 |
| ch2_div_o | output | 22 | Latch for selector 01 |
| ch1_ref_o | output | 22 | Latch for selector 10 |
| ch1_div_o | output | 22 | Latch for selector 11 |
| upd_o | output | 1 | One-cycle strobe on each transfer |
| upd_idx_o | output | 2 | Selector of the latest transfer |
| short_o | output | 1 | Latest transfer was not framed with exactly 22 bits |

## Verification
A shift and a transfer can fall in the same cycle. The bench provokes this by raising the serial clock and the load strobe on the same system clock edge, with the last bit of a 21-bit prefix already set up on the data line. The result is judged by checking that the loaded latch holds the full word, including that final bit, that the word goes to the latch named by that bit, and that `short_o` stays clear. A cycle-by-cycle behavioural model of the same rule is also compared with the outputs on every clock.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int WORD_W      = 22;
  localparam int SEL_W       = 2;
  localparam int N_LATCH     = 1 << SEL_W;
  localparam int SYNC_STAGES = 2;
  localparam int N_LINES     = 3;
  localparam int CNT_W       = $clog2(WORD_W + 2);

  // positions of the serial lines in the synchroniser vector
  localparam int LINE_SCK = 0;
  localparam int LINE_DAT = 1;
  localparam int LINE_LE  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CH2_REF = 2'd0,
    SEL_CH2_DIV = 2'd1,
    SEL_CH1_REF = 2'd2,
    SEL_CH1_DIV = 2'd3
  } sel_e;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_r;
    logic [STAGES-1:0] chain_nx;
    logic              prev_r;
    logic              prev_nx;

    always_comb begin
      chain_nx = {chain_r[STAGES-2:0], async_i[g]};
      prev_nx  = chain_r[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_r <= '0;
        prev_r  <= 1'b0;
      end else begin
        chain_r <= chain_nx;
        prev_r  <= prev_nx;
      end
    end

    assign level_o[g] = chain_r[STAGES-1];
    assign rise_o[g]  = chain_r[STAGES-1] & ~prev_r;
  end
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int WORD_W = 22,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              load_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr_r, sr_nx;
  logic [CNT_W-1:0]  cnt_r, cnt_inc, cnt_nx;
  logic              cnt_en;

  always_comb begin
    sr_nx   = sr_r;
    cnt_inc = cnt_r;
    if (shift_en_i) begin
      sr_nx = {sr_r[WORD_W-2:0], bit_i};
      if (cnt_r != CNT_SAT) begin
        cnt_inc = cnt_r + 1'b1;
      end
    end
    cnt_nx = load_en_i ? '0 : cnt_inc;
    cnt_en = shift_en_i | load_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_r <= '0;
    end else if (shift_en_i) begin
      sr_r <= sr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (cnt_en) begin
      cnt_r <= cnt_nx;
    end
  end

  // the word and count as they stand after this cycle's shift (R10)
  assign word_o = sr_nx;
  assign full_o = (cnt_inc == CNT_FULL);
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank #(
  parameter int WORD_W  = 22,
  parameter int SEL_W   = 2,
  parameter int N_LATCH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_en_i,
  input  logic [WORD_W-1:0]               word_i,
  input  logic                            full_i,
  output logic [N_LATCH-1:0][WORD_W-1:0]  lat_o,
  output logic                            upd_o,
  output logic [SEL_W-1:0]                idx_o,
  output logic                            short_o
);
  logic [SEL_W-1:0] sel;
  logic             upd_r, upd_nx;
  logic [SEL_W-1:0] idx_r, idx_nx;
  logic             short_r, short_nx;

  assign sel = word_i[SEL_W-1:0];

  for (genvar g = 0; g < N_LATCH; g++) begin : g_lat
    logic              wr_en;
    logic [WORD_W-1:0] lat_r;

    assign wr_en = load_en_i && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_r <= '0;
      end else if (wr_en) begin
        lat_r <= word_i;
      end
    end

    assign lat_o[g] = lat_r;
  end

  always_comb begin
    upd_nx   = load_en_i;
    idx_nx   = load_en_i ? sel : idx_r;
    short_nx = load_en_i ? ~full_i : short_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_r   <= 1'b0;
      idx_r   <= '0;
      short_r <= 1'b0;
    end else begin
      upd_r   <= upd_nx;
      idx_r   <= idx_nx;
      short_r <= short_nx;
    end
  end

  assign upd_o   = upd_r;
  assign idx_o   = idx_r;
  assign short_o = short_r;
endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
  import cfg3w_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_le_i,
  output logic [W-1:0]     ch2_ref_o,
  output logic [W-1:0]     ch2_div_o,
  output logic [W-1:0]     ch1_ref_o,
  output logic [W-1:0]     ch1_div_o,
  output logic             upd_o,
  output logic [SEL_W-1:0] upd_idx_o,
  output logic             short_o
);
  // reset: asserted at once, released on the clock
  logic rst_meta_r, rst_core_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_r <= 1'b0;
      rst_core_r <= 1'b0;
    end else begin
      rst_meta_r <= 1'b1;
      rst_core_r <= rst_meta_r;
    end
  end

  logic [N_LINES-1:0] lines_async, lines_lvl, lines_rise;
  logic [W-1:0]       word_next;
  logic               word_full;
  logic [N_LATCH-1:0][W-1:0] lat;

  always_comb begin
    lines_async           = '0;
    lines_async[LINE_SCK] = ser_clk_i;
    lines_async[LINE_DAT] = ser_dat_i;
    lines_async[LINE_LE]  = ser_le_i;
  end

  cfg3w_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_r),
    .async_i (lines_async),
    .level_o (lines_lvl),
    .rise_o  (lines_rise)
  );

  cfg3w_shift #(.WORD_W(W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_core_r),
    .shift_en_i (lines_rise[LINE_SCK]),
    .bit_i      (lines_lvl[LINE_DAT]),
    .load_en_i  (lines_rise[LINE_LE]),
    .word_o     (word_next),
    .full_o     (word_full)
  );

  cfg3w_bank #(.WORD_W(W), .SEL_W(SEL_W), .N_LATCH(N_LATCH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_r),
    .load_en_i (lines_rise[LINE_LE]),
    .word_i    (word_next),
    .full_i    (word_full),
    .lat_o     (lat),
    .upd_o     (upd_o),
    .idx_o     (upd_idx_o),
    .short_o   (short_o)
  );

  assign ch2_ref_o = lat[SEL_CH2_REF];
  assign ch2_div_o = lat[SEL_CH2_DIV];
  assign ch1_ref_o = lat[SEL_CH1_REF];
  assign ch1_div_o = lat[SEL_CH1_DIV];

  logic unused_lvl;
  assign unused_lvl = ^{lines_lvl[LINE_SCK], lines_lvl[LINE_LE]};
endmodule

// File: rtl/cfg3w_loader_chk.sv
module cfg3w_loader_chk #(
  parameter int W = 22
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ch2_ref_o,
  input logic [W-1:0] ch2_div_o,
  input logic [W-1:0] ch1_ref_o,
  input logic [W-1:0] ch1_div_o,
  input logic         upd_o,
  input logic [1:0]   upd_idx_o,
  input logic         short_o
);
  logic [W-1:0] picked;
  always_comb begin
    case (upd_idx_o)
      2'd0:    picked = ch2_ref_o;
      2'd1:    picked = ch2_div_o;
      2'd2:    picked = ch1_ref_o;
      default: picked = ch1_div_o;
    endcase
  end

  assert_upd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(ch2_ref_o) && $stable(ch2_div_o) && $stable(ch1_ref_o) && $stable(ch1_div_o)));

  assert_idx_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (picked[1:0] == upd_idx_o));

  assert_keep_ch2ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_idx_o != 2'd0) |-> $stable(ch2_ref_o));
  assert_keep_ch2div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_idx_o != 2'd1) |-> $stable(ch2_div_o));
  assert_keep_ch1ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_idx_o != 2'd2) |-> $stable(ch1_ref_o));
  assert_keep_ch1div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_idx_o != 2'd3) |-> $stable(ch1_div_o));

  assert_short_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(short_o));

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(upd_idx_o));
endmodule

bind cfg3w_loader cfg3w_loader_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch2_ref_o (ch2_ref_o),
  .ch2_div_o (ch2_div_o),
  .ch1_ref_o (ch1_ref_o),
  .ch1_div_o (ch1_div_o),
  .upd_o     (upd_o),
  .upd_idx_o (upd_idx_o),
  .short_o   (short_o)
);

// File: tb/sim_cfg3w_loader.sv
`timescale 1ns/1ps
module sim_cfg3w_loader;
  localparam int WW = 22;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, sck, sdat, sle;
  logic [WW-1:0] ch2_ref, ch2_div, ch1_ref, ch1_div;
  logic          upd, short_f;
  logic [1:0]    idx;

  cfg3w_loader u0 (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sck), .ser_dat_i(sdat), .ser_le_i(sle),
    .ch2_ref_o(ch2_ref), .ch2_div_o(ch2_div), .ch1_ref_o(ch1_ref), .ch1_div_o(ch1_div),
    .upd_o(upd), .upd_idx_o(idx), .short_o(short_f)
  );

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [WW-1:0] m_sr;
  logic [WW-1:0] m_lat [4];
  int            m_cnt;
  logic          m_upd, m_short;
  logic [1:0]    m_idx;
  bit            hc[$], hd[$], hl[$];
  int            since_rel;

  always @(posedge clk or negedge rst_n) begin
    bit cr, lr, db;
    if (!rst_n) begin
      m_sr = '0; m_cnt = 0; m_upd = 0; m_short = 0; m_idx = 0;
      for (int i = 0; i < 4; i++) m_lat[i] = '0;
      hc = '{0, 0, 0}; hd = '{0, 0, 0}; hl = '{0, 0, 0};
      since_rel = 0;
    end else if (since_rel < 2) begin
      since_rel++;
    end else begin
      cr = hc[1] && !hc[2];
      lr = hl[1] && !hl[2];
      db = hd[1];
      m_upd = 1'b0;
      if (cr) begin
        m_sr = {m_sr[WW-2:0], db};
        if (m_cnt < WW + 1) m_cnt++;
      end
      if (lr) begin
        m_lat[m_sr[1:0]] = m_sr;
        m_short = (m_cnt != WW);
        m_cnt = 0;
        m_upd = 1'b1;
        m_idx = m_sr[1:0];
      end
      hc.push_front(sck);  void'(hc.pop_back());
      hd.push_front(sdat); void'(hd.pop_back());
      hl.push_front(sle);  void'(hl.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R5 ch2_ref model", 32'(ch2_ref), 32'(m_lat[0]));
      cmp("R5 ch2_div model", 32'(ch2_div), 32'(m_lat[1]));
      cmp("R5 ch1_ref model", 32'(ch1_ref), 32'(m_lat[2]));
      cmp("R5 ch1_div model", 32'(ch1_div), 32'(m_lat[3]));
      cmp("R7 upd model", 32'(upd), 32'(m_upd));
      cmp("R7 idx model", 32'(idx), 32'(m_idx));
      cmp("R8 short model", 32'(short_f), 32'(m_short));
      if (upd) pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i];
      tick(3);
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
    end
  endtask

  task automatic do_load();
    sle = 1'b1;
    tick(4);
    sle = 1'b0;
    tick(4);
  endtask

  localparam logic [WW-1:0] WA = {20'hABCDE, 2'b00};
  localparam logic [WW-1:0] WB = {20'h13579, 2'b01};
  localparam logic [WW-1:0] WC = {20'h2468A, 2'b10};
  localparam logic [WW-1:0] WD = {20'hFEDCB, 2'b11};
  localparam logic [WW-1:0] WE = {20'h0F0F0, 2'b01};
  localparam logic [WW-1:0] WS = {20'h5A5A5, 2'b11};
  localparam logic [24:0]   V25 = 25'h1ABCDE2;

  initial begin
    int p0;
    rst_n = 1'b0; sck = 1'b0; sdat = 1'b0; sle = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R9 reset state
    cmp("R9 ch2_ref", 32'(ch2_ref), 0);
    cmp("R9 ch2_div", 32'(ch2_div), 0);
    cmp("R9 ch1_ref", 32'(ch1_ref), 0);
    cmp("R9 ch1_div", 32'(ch1_div), 0);
    cmp("R9 upd/idx/short", {29'd0, upd, idx, short_f}, 0);

    // R1 latency, R2 bit order, R5 decode, R6 full word
    send_bits(32'(WA), WW);
    sle = 1'b1;
    tick(2);
    cmp("R1 no update yet", 32'(upd), 0);
    tick(1);
    cmp("R1 update at third edge", 32'(upd), 1);
    cmp("R2 word msb first", 32'(ch2_ref), 32'(WA));
    cmp("R6 ref field", 32'(ch2_ref[15:2]), 32'(WA[15:2]));
    tick(1);
    cmp("R7 one cycle strobe", 32'(upd), 0);
    cmp("R5 others untouched", 32'(ch2_div | ch1_ref | ch1_div), 0);
    sle = 1'b0;
    tick(4);
    cmp("R8 exact frame clear", 32'(short_f), 0);

    send_bits(32'(WB), WW); do_load();
    cmp("R5 sel 01", 32'(ch2_div), 32'(WB));
    cmp("R7 idx 01", 32'(idx), 1);
    send_bits(32'(WC), WW); do_load();
    cmp("R5 sel 10", 32'(ch1_ref), 32'(WC));
    send_bits(32'(WD), WW); do_load();
    cmp("R5 sel 11", 32'(ch1_div), 32'(WD));
    cmp("R5 sel 00 kept", 32'(ch2_ref), 32'(WA));

    // R3: data wiggles with no serial clock rise
    for (int i = 0; i < 20; i++) begin
      sdat = ~sdat;
      tick(2);
    end
    do_load();
    cmp("R3 no shift", 32'(ch1_div), 32'(WD));
    cmp("R8 zero bits short", 32'(short_f), 1);

    // R4: strobe held high while a word is shifted in
    p0 = pulses;
    sle = 1'b1;
    tick(6);
    send_bits(32'(WE), WW);
    tick(10);
    cmp("R4 single transfer", pulses - p0, 1);
    cmp("R4 no load while high", 32'(ch2_div), 32'(WB));
    sle = 1'b0;
    tick(4);
    do_load();
    cmp("R4 bits kept for next rise", 32'(ch2_div), 32'(WE));
    cmp("R8 bits during high count", 32'(short_f), 0);

    // R8: short and long frames
    send_bits(32'h2B5, 10); do_load();
    cmp("R8 short frame", 32'(short_f), 1);
    send_bits(32'(V25), 25); do_load();
    cmp("R8 long frame", 32'(short_f), 1);
    cmp("R8 long frame content", 32'(ch1_ref), 32'(V25[21:0]));
    send_bits(32'(WC), WW); do_load();
    cmp("R8 flag cleared", 32'(short_f), 0);

    // R10: last shift and load in the same cycle
    send_bits(32'(WS >> 1), WW - 1);
    sdat = WS[0];
    tick(3);
    sck = 1'b1;
    sle = 1'b1;
    tick(4);
    sck = 1'b0;
    sle = 1'b0;
    tick(4);
    cmp("R10 word includes last bit", 32'(ch1_div), 32'(WS));
    cmp("R10 count includes last bit", 32'(short_f), 0);
    cmp("R10 idx", 32'(idx), 3);

    tick(5);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule